// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block lets a processor run single-lane SPI transactions against up to three serial NOR flash devices through three word-wide registers. Software queues every byte of a transaction (the opcode, then the address bytes most significant first, then any program data) one per write into a byte-wide transmit queue. A single write to the control register then picks the device, sets how many dummy clocks follow the transmit phase and how many response bytes to collect, and launches the transfer.

The engine drives SPI mode 0 with SCK idle low. It walks through seven named states. ST_IDLE moves to ST_LEAD on an accepted start. ST_LEAD holds chip select low for one SCK period. It then moves to ST_SEND when bytes are queued, otherwise to the first phase that has work. ST_SEND shifts out queued bytes until the queue is empty. It then moves to ST_WAIT when the dummy count is non-zero, to ST_RECV when bytes are requested, and otherwise to ST_TAIL. ST_WAIT gives one SCK per dummy cycle and moves to ST_RECV, or to ST_TAIL when no bytes are requested. ST_RECV collects the response bytes into a receive queue and moves to ST_TAIL after the last one. ST_TAIL holds chip select low for one SCK period. ST_GAP holds it high for one more period and then returns to ST_IDLE.

Software knows a write has finished when the transmit level reads zero. It knows a read has finished when the receive level equals the requested count. It then pops the response bytes from the data register.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: Registers are decoded by bus_addr[3:2]: 0 is control, 1 is level, 2 is data. A data write pushes bus_wdata[7:0] into the transmit queue. A level read returns the receive level in bits [9:0] and the transmit level in bits [21:12]. Reads return data one cycle after bus_rd.
- R2: Queued bytes go out in queue order, MSB first, on MOSI. MOSI changes only while SCK is low. It is sampled by the device on the SCK rising edge. SCK is low whenever no chip select is active.
- R3: A transaction with N queued bytes, D dummy cycles (control bits [15:8]) and B read-back bytes (control bits [25:16]) gives exactly 8N + D + 8B SCK rising edges.
- R4: Response bytes are sampled on MISO at SCK rising edges, MSB first. They are pushed in arrival order, and each data read pops one in bits [7:0]. At completion the receive level equals B.
- R5: Control bits [5:4] select which cs_n line is driven low. Only one line is ever low. A start with a select value of 3 or more is ignored.
- R6: With SCK_DIV system clocks per SCK period, the first SCK rise comes 1.5 SCK periods after chip select falls. Chip select rises one SCK period after the last SCK fall, and stays high at least one SCK period before the next transaction.
- R7: A control write with bit 2 set starts a transaction only when bit 1 (enable) is also set in that write and the engine is idle. Otherwise no chip select moves and the queues are untouched.
- R8: A control write with bit 0 set empties both queues and returns the engine to ST_IDLE with all chip selects high. Bit 0 takes precedence over bit 2.
- R9: Control reads return bit 2 as 1 while a transaction is in progress (ST_LEAD through ST_GAP) and 0 otherwise.
- R10: A data write to a full transmit queue (512 entries) is dropped, so the level stays at 512. A data read from an empty receive queue returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| sck | output | 1 | SPI serial clock, idle low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | NCS | Active-low chip selects |

## Verification
A corrupted bit counter or shift register shows up at the flash side within one byte time, as a wrong byte against the queue of expected bytes or as a wrong total count of SCK edges. A state machine stuck or skipping a phase changes the lead or tail time around chip select, or the edge total, within the same transaction. Queue pointer or level faults show in the level register read right after the transaction, and misordered response bytes show in the next data pops. Start and reset filtering is observed directly on cs_n and on the levels a few cycles after the control write.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_TAIL,
        ST_GAP
    } eng_state_t;

    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_LEVEL = 2'd1;
    localparam logic [1:0] REG_DATA  = 2'd2;

endpackage

// File: rtl/spi_eng_fifo.sv
module spi_eng_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 512,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty,
    output logic [LW-1:0]    level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full); // R10
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R8

endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
    import spi_eng_pkg::*;
#(
    parameter int NCS     = 3,
    parameter int SCK_DIV = 4,
    parameter int DMW     = 8,
    parameter int CNTW    = 10,
    parameter int CSW     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            start,
    input  logic [CSW-1:0]  start_cs,
    input  logic [DMW-1:0]  start_dummy,
    input  logic [CNTW-1:0] start_rb,
    input  logic            tx_empty,
    input  logic [7:0]      tx_data,
    output logic            tx_pop,
    output logic            rx_push,
    output logic [7:0]      rx_data,
    input  logic            miso,
    output logic            sck,
    output logic            mosi,
    output logic [NCS-1:0]  cs_n,
    output logic            busy
);
    localparam int HALF = (SCK_DIV < 2) ? 1 : SCK_DIV / 2;
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

    eng_state_t      state, nxt;
    logic [HW-1:0]   hcnt;
    logic            ph;
    logic [2:0]      bitc;
    logic [7:0]      sreg, rsh;
    logic [DMW-1:0]  dcnt;
    logic [CNTW-1:0] rcnt;
    logic [CSW-1:0]  cs_q;
    logic            tick, rise, period_end, byte_end;
    eng_state_t      after_send;

    assign tick       = (hcnt == HW'(HALF - 1));
    assign rise       = tick && !ph;
    assign period_end = tick && ph;
    assign byte_end   = period_end && (bitc == 3'd7);

    always_comb begin
        if (dcnt != '0)      after_send = ST_WAIT;
        else if (rcnt != '0) after_send = ST_RECV;
        else                 after_send = ST_TAIL;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_LEAD;
            ST_LEAD: if (period_end) nxt = tx_empty ? after_send : ST_SEND;
            ST_SEND: if (byte_end && tx_empty) nxt = after_send;
            ST_WAIT: if (period_end && dcnt == DMW'(1))
                         nxt = (rcnt != '0) ? ST_RECV : ST_TAIL;
            ST_RECV: if (byte_end && rcnt == CNTW'(1)) nxt = ST_TAIL;
            ST_TAIL: if (period_end) nxt = ST_GAP;
            ST_GAP:  if (period_end) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= ST_IDLE;
        else if (flush) state <= ST_IDLE;
        else            state <= nxt;
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        sck     = ph && (state == ST_SEND || state == ST_WAIT || state == ST_RECV);
        mosi    = (state == ST_SEND) ? sreg[7] : 1'b0;
        cs_n    = (busy && state != ST_GAP) ? ~(NCS'(1) << cs_q) : '1;
        tx_pop  = !tx_empty && ((state == ST_LEAD && period_end) ||
                                (state == ST_SEND && byte_end));
        rx_push = (state == ST_RECV) && byte_end;
        rx_data = rsh;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0; ph <= 1'b0; bitc <= '0; sreg <= '0; rsh <= '0;
            dcnt <= '0; rcnt <= '0; cs_q <= '0;
        end else if (flush) begin
            hcnt <= '0; ph <= 1'b0; bitc <= '0;
            dcnt <= '0; rcnt <= '0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                hcnt <= '0; ph <= 1'b0; bitc <= '0;
                cs_q <= start_cs;
                dcnt <= start_dummy;
                rcnt <= start_rb;
            end
        end else begin
            if (tick) begin
                hcnt <= '0;
                ph   <= ~ph;
            end else begin
                hcnt <= hcnt + 1'b1;
            end
            if (state == ST_RECV && rise) rsh <= {rsh[6:0], miso};
            if (tx_pop) begin
                sreg <= tx_data;
                bitc <= '0;
            end else if (period_end && (state == ST_SEND || state == ST_RECV)) begin
                sreg <= {sreg[6:0], 1'b0};
                bitc <= bitc + 1'b1;
            end
            if (period_end && state == ST_WAIT) dcnt <= dcnt - 1'b1;
            if (rx_push) rcnt <= rcnt - 1'b1;
        end
    end

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi)); // R2
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R5
    AST_SCK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !(&cs_n)); // R6
    AST_SELECT_DROPS_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (state == ST_TAIL && period_end) |=> (&cs_n)); // R6

endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine
    import spi_eng_pkg::*;
#(
    parameter int NCS     = 3,
    parameter int SCK_DIV = 4,
    parameter int DEPTH   = 512,
    parameter int DMW     = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [3:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           sck,
    output logic           mosi,
    input  logic           miso,
    output logic [NCS-1:0] cs_n
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int CSW  = (NCS > 1) ? $clog2(NCS) : 1;
    localparam logic [CSW:0] NCS_L = NCS[CSW:0];

    logic [1:0]      sel;
    logic            wr_ctrl, rd_data;
    logic            ctrl_en;
    logic [CSW-1:0]  ctrl_cs;
    logic [DMW-1:0]  ctrl_dummy;
    logic [CNTW-1:0] ctrl_rb;
    logic            flush, start, busy;
    logic            tx_push, tx_pop, tx_full, tx_empty;
    logic            rx_push, rx_full, rx_empty;
    logic [7:0]      tx_dout, rx_din, rx_dout;
    logic [CNTW-1:0] tx_lvl, rx_lvl;
    logic [31:0]     ctrl_view, lvl_view;
    logic            unused_bits;

    assign sel         = bus_addr[3:2];
    assign wr_ctrl     = bus_wr && sel == REG_CTRL;
    assign rd_data     = bus_rd && sel == REG_DATA;
    assign flush       = wr_ctrl && bus_wdata[0];
    assign start       = wr_ctrl && !bus_wdata[0] && bus_wdata[1] && bus_wdata[2] &&
                         ({1'b0, bus_wdata[4 +: CSW]} < NCS_L) && !busy;
    assign tx_push     = bus_wr && sel == REG_DATA;
    assign unused_bits = ^{bus_wdata, bus_addr[1:0], rx_full, tx_full};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0; ctrl_cs <= '0; ctrl_dummy <= '0; ctrl_rb <= '0;
        end else if (wr_ctrl) begin
            ctrl_en    <= bus_wdata[1];
            ctrl_cs    <= bus_wdata[4 +: CSW];
            ctrl_dummy <= bus_wdata[8 +: DMW];
            ctrl_rb    <= bus_wdata[16 +: CNTW];
        end
    end

    always_comb begin
        ctrl_view = '0;
        ctrl_view[1]          = ctrl_en;
        ctrl_view[2]          = busy;
        ctrl_view[4 +: CSW]   = ctrl_cs;
        ctrl_view[8 +: DMW]   = ctrl_dummy;
        ctrl_view[16 +: CNTW] = ctrl_rb;
        lvl_view = '0;
        lvl_view[0 +: CNTW]   = rx_lvl;
        lvl_view[12 +: CNTW]  = tx_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (sel)
                REG_CTRL:  bus_rdata <= ctrl_view;
                REG_LEVEL: bus_rdata <= lvl_view;
                REG_DATA:  bus_rdata <= rx_empty ? 32'd0 : {24'd0, rx_dout};
                default:   bus_rdata <= '0;
            endcase
        end
    end

    spi_eng_fifo #(.WIDTH(8), .DEPTH(DEPTH), .LW(CNTW)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_dout),
        .full(tx_full), .empty(tx_empty), .level(tx_lvl));

    spi_eng_fifo #(.WIDTH(8), .DEPTH(DEPTH), .LW(CNTW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_push), .din(rx_din), .pop(rd_data), .dout(rx_dout),
        .full(rx_full), .empty(rx_empty), .level(rx_lvl));

    spi_eng_shifter #(.NCS(NCS), .SCK_DIV(SCK_DIV), .DMW(DMW), .CNTW(CNTW), .CSW(CSW)) u_shift (
        .clk(clk), .rst_n(rst_n), .flush(flush), .start(start),
        .start_cs(bus_wdata[4 +: CSW]), .start_dummy(bus_wdata[8 +: DMW]),
        .start_rb(bus_wdata[16 +: CNTW]),
        .tx_empty(tx_empty), .tx_data(tx_dout), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_din),
        .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy));

    AST_DISABLED_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !bus_wdata[1] && !busy) |=> (&cs_n)); // R7
    AST_RESET_RELEASES_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (&cs_n && !sck)); // R8

endmodule

// File: tb/spi_flash_cmd_engine_test.sv
module spi_flash_cmd_engine_test;
    localparam int NCS = 3;
    localparam int DIV = 4;
    localparam int HALF = DIV / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sck, mosi, miso;
    logic [NCS-1:0] cs_n;

    int checks = 0, fails = 0;
    int rise_cnt = 0, cur_ntx = 0;
    int lead_cnt = 0, tail_cnt = 0;
    bit sck_seen = 0, prev_low = 0, any_low = 0;
    logic [NCS-1:0] seen_mask = '0;
    logic [7:0] mbyte = '0;
    logic [7:0] exp_q[$];
    logic [7:0] txq[$];
    logic cs_low;

    always #10 clk = ~clk;

    spi_flash_cmd_engine #(.NCS(NCS), .SCK_DIV(DIV), .DEPTH(512), .DMW(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

    assign cs_low = ~&cs_n;

    function automatic logic [7:0] resp_byte(input int j);
        return 8'(j * 29 + 53);
    endfunction
    function automatic logic resp_bit(input int k);
        logic [7:0] b;
        b = resp_byte(k / 8);
        return b[7 - (k % 8)];
    endfunction
    function automatic logic [7:0] exp_rx(input int ntx, input int dmy, input int i);
        logic [7:0] v;
        for (int b = 0; b < 8; b++) v[7 - b] = resp_bit(8 * ntx + dmy + 8 * i + b);
        return v;
    endfunction

    assign miso = cs_low ? resp_bit(rise_cnt) : 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: flash-side receiver, compares against scoreboard queue
    always @(posedge sck) begin
        if (cs_low) begin
            mbyte = {mbyte[6:0], mosi};
            rise_cnt++;
            if (rise_cnt % 8 == 0 && rise_cnt / 8 <= cur_ntx) begin
                if (exp_q.size() == 0) chk(0, "R2 unexpected byte", mbyte, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(mbyte == e, "R2 mosi byte", mbyte, e);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cs_low && !prev_low) begin
            lead_cnt = 0; tail_cnt = 0; sck_seen = 0; seen_mask = '0;
        end
        if (cs_low) begin
            any_low = 1;
            seen_mask = seen_mask | ~cs_n;
            if (sck) begin sck_seen = 1; tail_cnt = 0; end
            else begin
                if (!sck_seen) lead_cnt++;
                tail_cnt++;
            end
        end
        prev_low = cs_low;
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input int csel, input int dmy, input int rb);
        return 32'h6 | (32'(csel) << 4) | (32'(dmy) << 8) | (32'(rb) << 16);
    endfunction

    // driver: queues bytes, records expectations, launches, then checks
    task automatic run_txn(input int csel, input int dmy, input int rb);
        logic [31:0] d;
        int ntx;
        ntx = txq.size();
        foreach (txq[i]) begin
            wr(4'h8, {24'd0, txq[i]});
            exp_q.push_back(txq[i]);
        end
        txq.delete();
        cur_ntx = ntx; rise_cnt = 0;
        wr(4'h0, ctrl_word(csel, dmy, rb));
        rd(4'h0, d);
        chk(d[2] == 1'b1, "R9 busy during transaction", d[2], 1);
        wait (!cs_low);
        repeat (2 * DIV) @(posedge clk);
        chk(rise_cnt == 8 * ntx + dmy + 8 * rb, "R3 sck edge total", rise_cnt, 8 * ntx + dmy + 8 * rb);
        chk(lead_cnt == DIV + HALF, "R6 lead time", lead_cnt, DIV + HALF);
        chk(tail_cnt == DIV, "R6 tail time", tail_cnt, DIV);
        chk(seen_mask == NCS'(1 << csel), "R5 select line", seen_mask, 1 << csel);
        chk(exp_q.size() == 0, "R2 all bytes sent", exp_q.size(), 0);
        rd(4'h0, d);
        chk(d[2] == 1'b0, "R9 idle after transaction", d[2], 0);
        rd(4'h4, d);
        chk(d[9:0] == 10'(rb), "R4 rx level", d[9:0], rb);
        chk(d[21:12] == 0, "R1 tx level drained", d[21:12], 0);
        for (int i = 0; i < rb; i++) begin
            rd(4'h8, d);
            chk(d == {24'd0, exp_rx(ntx, dmy, i)}, "R4 rx byte", d, exp_rx(ntx, dmy, i));
        end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state
        chk(cs_n == '1 && sck == 0, "R6 reset idle pins", {cs_n, sck}, {3'b111, 1'b0});
        rd(4'h4, d);
        chk(d == 0, "R1 reset levels", d, 0);

        // page-program style: opcode, 3 address bytes, 2 data
        txq = '{8'h02, 8'h12, 8'h34, 8'h56, 8'hA5, 8'h3C};
        run_txn(0, 0, 0);
        // plain read, 3-byte address, 4 bytes back
        txq = '{8'h03, 8'h00, 8'h10, 8'h20};
        run_txn(1, 0, 4);
        // fast read, 4-byte address, 8 dummy clocks, 3 bytes back
        txq = '{8'h0B, 8'h01, 8'h02, 8'h03, 8'h04};
        run_txn(2, 8, 3);
        // odd dummy count, opcode only
        txq = '{8'h9F};
        run_txn(0, 5, 2);

        // start with enable clear
        wr(4'h8, 32'h11); wr(4'h8, 32'h22);
        any_low = 0;
        wr(4'h0, 32'h4);
        repeat (40) @(posedge clk);
        chk(any_low == 0, "R7 disabled start ignored", any_low, 0);
        rd(4'h4, d);
        chk(d[21:12] == 2, "R7 tx queue kept", d[21:12], 2);
        // out-of-range select
        wr(4'h0, ctrl_word(3, 0, 0));
        repeat (40) @(posedge clk);
        chk(any_low == 0, "R5 select 3 ignored", any_low, 0);
        // soft reset flushes
        wr(4'h0, 32'h1);
        rd(4'h4, d);
        chk(d == 0, "R8 flush levels", d, 0);

        // start while busy is ignored
        txq = '{8'h03, 8'hAA, 8'hBB, 8'hCC};
        foreach (txq[i]) begin wr(4'h8, {24'd0, txq[i]}); exp_q.push_back(txq[i]); end
        txq.delete();
        cur_ntx = 4; rise_cnt = 0;
        wr(4'h0, ctrl_word(0, 0, 1));
        repeat (20) @(posedge clk);
        wr(4'h0, ctrl_word(2, 3, 2));
        wait (!cs_low);
        repeat (2 * DIV) @(posedge clk);
        chk(seen_mask == 3'b001, "R7 busy start kept select", seen_mask, 1);
        chk(rise_cnt == 40, "R7 busy start kept length", rise_cnt, 40);
        rd(4'h8, d);
        chk(d[7:0] == exp_rx(4, 0, 0), "R4 rx after busy start", d, exp_rx(4, 0, 0));

        // soft reset mid transaction
        txq = '{8'h03, 8'h01, 8'h02, 8'h03};
        foreach (txq[i]) wr(4'h8, {24'd0, txq[i]});
        txq.delete();
        cur_ntx = 0; rise_cnt = 0;
        wr(4'h0, ctrl_word(1, 0, 4));
        repeat (25) @(posedge clk);
        wr(4'h0, 32'h3);
        chk(cs_n == '1 && sck == 0, "R8 abort releases select", {cs_n, sck}, {3'b111, 1'b0});
        rd(4'h4, d);
        chk(d == 0, "R8 abort flush levels", d, 0);
        rd(4'h0, d);
        chk(d[2] == 0, "R8 abort idle", d[2], 0);

        // overflow and empty read
        for (int i = 0; i < 513; i++) wr(4'h8, 32'(i));
        rd(4'h4, d);
        chk(d[21:12] == 512, "R10 tx level saturates", d[21:12], 512);
        wr(4'h0, 32'h1);
        rd(4'h8, d);
        chk(d == 0, "R10 empty rx read", d, 0);
        rd(4'h4, d);
        chk(d == 0, "R1 levels after flush", d, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule